// File: doc/BRIEF.md
# Priority Content-Addressable Table with Empty-Slot Tracking

This block holds a table of 64-bit words, each paired with an emptiness flag. A compare operation searches every occupied word at once against a search key. It reports whether any word matched and the lowest matching index, and it raises a flag when more than one occupied word matched. Empty words never take part in a search. Lower indices always win, both for matches and for free-slot selection.

A priority encoder over the emptiness flags tracks the lowest empty slot. That slot is the target of the "write to next free" operation, so the table fills from index 0 upward. The same encoder drives an active-low full indication. Words can also be written or read at an explicit index, and their emptiness flags can be set or cleared without touching the stored data.

A small controller records what kind of result the status word holds. Its state register has three named states. ST_RESET is entered on reset. ST_MATCH is entered on the transition taken by a compare. ST_ACCESS is entered on the transition taken by a write-at-index, a read-at-index or an accepted write-to-next-free. All other operations leave the state where it is. One operation is issued per clock on `op`.

Top module: `prio_cam`

## Requirements
- R1: After reset every entry is empty, `full_n` is 1, the free index is 0, `match_found` and `multi_hit` are 0, and the result kind in `status_word` is 00.
- R2: Operation code 1 (write at index) stores `wdata` and the flag `vb_in` (1 = empty, 0 = occupied) at `addr`. Operation code 3 (read at index) returns the stored word on `rdata` and its flag on `rd_vb`, both visible after the clock edge that accepts the read.
- R3: Operation code 2 (write to next free) stores `wdata` and `vb_in` at the lowest-index empty entry, so successive writes fill indices 0, 1, 2 and so on. When the table is full this operation changes nothing.
- R4: `next_free_word` carries `page` in bits 19:16 and the lowest empty index in bits 12:0, with all other bits 0. The index reads 0 when the table is full. It reflects a change from the clock edge that made it.
- R5: `full_n` is 0 exactly when no entry is empty.
- R6: Operation code 6 (compare) uses `wdata` as the key. It registers `match_found` and places in the active field the lowest index of an occupied entry equal to the key, or 0 on a miss. Empty entries never match. Both results hold until the next compare.
- R7: `multi_hit` is registered with each compare and is 1 exactly when two or more occupied entries equal the key.
- R8: Operation code 4 marks the entry at `addr` empty and operation code 5 marks it occupied. Neither changes the stored data. Code 0 is a no-operation.
- R9: `status_word` holds the result kind in bits 25:24 (00 reset, 01 match, 10 memory access), `page` in bits 19:16 and the active index in bits 12:0, with all other bits 0. A write or read at an index, or an accepted write-to-next-free, sets kind 10 and puts its target index in the active field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 3 | Operation code for this cycle |
| addr | input | AW | Entry index for indexed operations |
| wdata | input | 64 | Write data or compare key |
| vb_in | input | 1 | Emptiness flag to store on writes (1 = empty) |
| page | input | 4 | Page number reported in both status words |
| rdata | output | 64 | Word returned by the last read |
| rd_vb | output | 1 | Emptiness flag returned by the last read |
| match_found | output | 1 | Last compare found an occupied equal entry |
| multi_hit | output | 1 | Last compare found two or more equal entries |
| full_n | output | 1 | Low when every entry is occupied |
| status_word | output | 32 | Result kind, page and active index |
| next_free_word | output | 32 | Page and lowest empty index |

## Verification
The bench builds the table with DEPTH set to 16, which makes the index 4 bits wide. At that depth a handful of write-to-next-free operations fills the table. This brings the full flag, the ignored write when full and the free index wrapping to 0 within reach. It also lets punched holes be refilled in priority order. The bench draws data keys from only four values, so random traffic often leaves several occupied entries equal to one key. That exercises the lowest-index choice and the multiple-match flag.

// File: rtl/cam_pkg.sv
package cam_pkg;
    localparam int ACT_W  = 13;
    localparam int PAGE_W = 4;

    typedef enum logic [2:0] {
        OP_NOP        = 3'd0,
        OP_WR_AT      = 3'd1,
        OP_WR_NEXT    = 3'd2,
        OP_RD_AT      = 3'd3,
        OP_MARK_EMPTY = 3'd4,
        OP_MARK_VALID = 3'd5,
        OP_CMP        = 3'd6
    } cam_op_e;

    typedef enum logic [1:0] {
        ST_RESET  = 2'b00,
        ST_MATCH  = 2'b01,
        ST_ACCESS = 2'b10
    } res_state_e;
endpackage

// File: rtl/cam_prio_enc.sv
module cam_prio_enc #(
    parameter int N = 16,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] req,
    output logic         found,
    output logic [W-1:0] idx
);
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = W'(i);
        end
    end
endmodule

// File: rtl/cam_array.sv
module cam_array #(
    parameter int DEPTH = 512,
    parameter int DW    = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    widx,
    input  logic [DW-1:0]    wdata,
    input  logic             wvb,
    input  logic             flag_we,
    input  logic [AW-1:0]    flag_idx,
    input  logic             flag_val,
    input  logic             re,
    input  logic [AW-1:0]    ridx,
    input  logic [DW-1:0]    key,
    output logic [DW-1:0]    rdata,
    output logic             rvb,
    output logic [DEPTH-1:0] empty_vec,
    output logic [DEPTH-1:0] hit_vec
);
    logic [DW-1:0]    mem_q [DEPTH];
    logic [DEPTH-1:0] empty_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            empty_q <= '1;
            rdata   <= '0;
            rvb     <= 1'b1;
        end else begin
            if (we) begin
                mem_q[widx]   <= wdata;
                empty_q[widx] <= wvb;
            end
            if (flag_we) empty_q[flag_idx] <= flag_val;
            if (re) begin
                rdata <= mem_q[ridx];
                rvb   <= empty_q[ridx];
            end
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit_vec[g] = !empty_q[g] && (mem_q[g] == key);
    end

    assign empty_vec = empty_q;
endmodule

// File: rtl/cam_ctrl.sv
module cam_ctrl
    import cam_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cam_op_e          op,
    input  logic             next_ok,
    input  logic [AW-1:0]    addr_idx,
    input  logic [AW-1:0]    free_idx,
    input  logic             hit_any,
    input  logic [AW-1:0]    hit_idx,
    input  logic             hit_many,
    output res_state_e       state,
    output logic [ACT_W-1:0] active,
    output logic             hit_q,
    output logic             multi_q
);
    res_state_e state_d;

    always_comb begin
        state_d = state;
        unique case (op)
            OP_CMP:             state_d = ST_MATCH;
            OP_WR_AT, OP_RD_AT: state_d = ST_ACCESS;
            OP_WR_NEXT:         if (next_ok) state_d = ST_ACCESS;
            default:            state_d = state;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RESET;
        else        state <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= '0;
            hit_q   <= 1'b0;
            multi_q <= 1'b0;
        end else begin
            unique case (op)
                OP_CMP: begin
                    active  <= hit_any ? ACT_W'(hit_idx) : '0;
                    hit_q   <= hit_any;
                    multi_q <= hit_many;
                end
                OP_WR_AT, OP_RD_AT: active <= ACT_W'(addr_idx);
                OP_WR_NEXT:         if (next_ok) active <= ACT_W'(free_idx);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/prio_cam.sv
module prio_cam
    import cam_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int DW    = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    op,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          vb_in,
    input  logic [3:0]    page,
    output logic [DW-1:0] rdata,
    output logic          rd_vb,
    output logic          match_found,
    output logic          multi_hit,
    output logic          full_n,
    output logic [31:0]   status_word,
    output logic [31:0]   next_free_word
);
    cam_op_e          op_e;
    logic [DEPTH-1:0] empty_vec, hit_vec;
    logic             free_any, hit_any, hit_many;
    logic [AW-1:0]    free_idx, hit_idx;
    logic             wr_next_ok;
    res_state_e       state;
    logic [ACT_W-1:0] active;

    assign op_e       = cam_op_e'(op);
    assign wr_next_ok = (op_e == OP_WR_NEXT) && free_any;
    assign hit_many   = |(hit_vec & (hit_vec - 1'b1));

    cam_array #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       ((op_e == OP_WR_AT) || wr_next_ok),
        .widx     (wr_next_ok ? free_idx : addr),
        .wdata    (wdata),
        .wvb      (vb_in),
        .flag_we  ((op_e == OP_MARK_EMPTY) || (op_e == OP_MARK_VALID)),
        .flag_idx (addr),
        .flag_val (op_e == OP_MARK_EMPTY),
        .re       (op_e == OP_RD_AT),
        .ridx     (addr),
        .key      (wdata),
        .rdata    (rdata),
        .rvb      (rd_vb),
        .empty_vec(empty_vec),
        .hit_vec  (hit_vec)
    );

    cam_prio_enc #(.N(DEPTH), .W(AW)) u_free_enc (
        .req  (empty_vec),
        .found(free_any),
        .idx  (free_idx)
    );

    cam_prio_enc #(.N(DEPTH), .W(AW)) u_hit_enc (
        .req  (hit_vec),
        .found(hit_any),
        .idx  (hit_idx)
    );

    cam_ctrl #(.AW(AW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op_e),
        .next_ok (wr_next_ok),
        .addr_idx(addr),
        .free_idx(free_idx),
        .hit_any (hit_any),
        .hit_idx (hit_idx),
        .hit_many(hit_many),
        .state   (state),
        .active  (active),
        .hit_q   (match_found),
        .multi_q (multi_hit)
    );

    assign full_n         = free_any;
    assign status_word    = {6'b0, state, 4'b0, page, 3'b0, active};
    assign next_free_word = {12'b0, page, 3'b0, ACT_W'(free_idx)};
endmodule

// File: rtl/prio_cam_chk.sv
module prio_cam_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  op,
    input logic        match_found,
    input logic        multi_hit,
    input logic        full_n,
    input logic [31:0] status_word,
    input logic [31:0] next_free_word
);
    AST_MULTI_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        multi_hit |-> match_found); // R7

    AST_CMP_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd6) |=> (status_word[25:24] == 2'b01)); // R9

    AST_STATUS_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word & ~32'h030F_1FFF) == 32'h0); // R9

    AST_FREE_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        (next_free_word & ~32'h000F_1FFF) == 32'h0); // R4

    AST_FULL_IGNORES_WRNEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd2 && !full_n) |=> (!full_n && $stable(status_word))); // R3

    AST_HIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (op != 3'd6) |=> ($stable(match_found) && $stable(multi_hit))); // R6

    AST_FULL_FREE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |-> (next_free_word[12:0] == 13'h0)); // R5
endmodule

bind prio_cam prio_cam_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .op            (op),
    .match_found   (match_found),
    .multi_hit     (multi_hit),
    .full_n        (full_n),
    .status_word   (status_word),
    .next_free_word(next_free_word)
);

// File: tb/prio_cam_tb_top.sv
`timescale 1ns/1ps
module prio_cam_tb_top;
    localparam int DEPTH = 16;
    localparam int AW    = 4;
    localparam logic [3:0] PG = 4'hA;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    op = 3'd0;
    logic [AW-1:0] addr = '0;
    logic [63:0]   wdata = '0;
    logic          vb_in = 1'b0;
    logic [3:0]    page = PG;
    logic [63:0]   rdata;
    logic          rd_vb, match_found, multi_hit, full_n;
    logic [31:0]   status_word, next_free_word;

    int n_chk = 0;
    int n_err = 0;

    logic [63:0] m_data [DEPTH];
    logic        m_emp  [DEPTH];

    always #2 clk = ~clk;

    prio_cam #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .op(op), .addr(addr), .wdata(wdata),
        .vb_in(vb_in), .page(page), .rdata(rdata), .rd_vb(rd_vb),
        .match_found(match_found), .multi_hit(multi_hit), .full_n(full_n),
        .status_word(status_word), .next_free_word(next_free_word)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int m_free();
        for (int i = 0; i < DEPTH; i++) if (m_emp[i]) return i;
        return -1;
    endfunction

    function automatic logic [31:0] exp_free_word();
        int f = m_free();
        return (32'(PG) << 16) | ((f < 0) ? 32'h0 : 32'(f));
    endfunction

    function automatic logic [31:0] exp_status(input logic [1:0] kind, input int act);
        return (32'(kind) << 24) | (32'(PG) << 16) | 32'(act);
    endfunction

    task automatic do_op(input logic [2:0] o, input int a, input logic [63:0] d, input logic v);
        int f;
        @(negedge clk);
        op = o; addr = AW'(a); wdata = d; vb_in = v;
        f = m_free();
        case (o)
            3'd1: begin m_data[a] = d; m_emp[a] = v; end
            3'd2: if (f >= 0) begin m_data[f] = d; m_emp[f] = v; end
            3'd4: m_emp[a] = 1'b1;
            3'd5: m_emp[a] = 1'b0;
            default: ;
        endcase
        @(posedge clk);
        #1;
        op = 3'd0;
    endtask

    task automatic check_free(input string tag);
        check({tag, " next_free_word"}, 64'(next_free_word), 64'(exp_free_word()));
        check({tag, " full_n"}, 64'(full_n), 64'(m_free() >= 0));
    endtask

    task automatic cmp_check(input string tag, input logic [63:0] key);
        int first = -1;
        int cnt = 0;
        for (int i = 0; i < DEPTH; i++)
            if (!m_emp[i] && m_data[i] == key) begin
                cnt++;
                if (first < 0) first = i;
            end
        do_op(3'd6, 0, key, 1'b0);
        check({tag, " R6 match_found"}, 64'(match_found), 64'(cnt > 0));
        check({tag, " R6 status active"}, 64'(status_word),
              64'(exp_status(2'b01, (first < 0) ? 0 : first)));
        check({tag, " R7 multi_hit"}, 64'(multi_hit), 64'(cnt > 1));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin m_data[i] = '0; m_emp[i] = 1'b1; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        check("R1 full_n", 64'(full_n), 64'd1);
        check("R1 next_free_word", 64'(next_free_word), 64'(32'h000A_0000));
        check("R1 status_word", 64'(status_word), 64'(32'h000A_0000));
        check("R1 match_found", 64'(match_found), 64'd0);
        check("R1 multi_hit", 64'(multi_hit), 64'd0);
    endtask

    task automatic t_wr_rd();
        do_op(3'd1, 5, 64'hDEAD_BEEF_0123_4567, 1'b0);
        check("R9 status after write at", 64'(status_word), 64'(exp_status(2'b10, 5)));
        check_free("R4 write at 5");
        do_op(3'd1, 9, 64'h1111_2222_3333_4444, 1'b1);
        do_op(3'd3, 5, 64'h0, 1'b0);
        check("R2 rdata idx5", rdata, 64'hDEAD_BEEF_0123_4567);
        check("R2 rd_vb idx5", 64'(rd_vb), 64'd0);
        check("R9 status after read", 64'(status_word), 64'(exp_status(2'b10, 5)));
        do_op(3'd3, 9, 64'h0, 1'b0);
        check("R2 rdata idx9", rdata, 64'h1111_2222_3333_4444);
        check("R2 rd_vb idx9", 64'(rd_vb), 64'd1);
    endtask

    task automatic t_fill();
        int f;
        for (int k = 0; k < DEPTH; k++) begin
            f = m_free();
            if (f >= 0) begin
                do_op(3'd2, 0, 64'(100 + k), 1'b0);
                check("R3 status after write next", 64'(status_word), 64'(exp_status(2'b10, f)));
                check_free("R4 R5 fill");
            end
        end
        check("R5 full_n when full", 64'(full_n), 64'd0);
        check("R4 free index 0 when full", 64'(next_free_word), 64'(32'h000A_0000));
        do_op(3'd2, 0, 64'hBAD, 1'b0);
        check("R3 write next ignored when full", 64'(full_n), 64'd0);
        do_op(3'd3, 0, 64'h0, 1'b0);
        check("R3 entry 0 unchanged", rdata, m_data[0]);
    endtask

    task automatic t_marks();
        logic [63:0] keep;
        keep = m_data[7];
        do_op(3'd4, 7, 64'h0, 1'b0);
        do_op(3'd4, 3, 64'h0, 1'b0);
        check_free("R8 mark empty holes");
        check("R4 lowest hole", 64'(next_free_word[12:0]), 64'd3);
        do_op(3'd5, 3, 64'h0, 1'b0);
        check("R8 mark valid moves free", 64'(next_free_word[12:0]), 64'd7);
        do_op(3'd3, 7, 64'h0, 1'b0);
        check("R8 data kept after mark empty", rdata, keep);
        check("R8 flag empty", 64'(rd_vb), 64'd1);
        do_op(3'd0, 0, 64'h0, 1'b0);
        check_free("R8 nop");
    endtask

    task automatic t_compare();
        do_op(3'd1, 2, 64'h55, 1'b0);
        do_op(3'd1, 11, 64'h55, 1'b0);
        do_op(3'd1, 6, 64'h55, 1'b1);
        cmp_check("multi", 64'h55);
        do_op(3'd4, 2, 64'h0, 1'b0);
        cmp_check("single", 64'h55);
        do_op(3'd0, 0, 64'h0, 1'b0);
        check("R6 hit holds", 64'(match_found), 64'd1);
        cmp_check("miss", 64'hFFFF_0000_FFFF_0000);
        cmp_check("empty excluded", m_data[7]);
    endtask

    task automatic t_random();
        logic [15:0] lf = 16'hACE1;
        logic [2:0]  o;
        for (int n = 0; n < 300; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            case (lf[2:0])
                3'd0, 3'd1: o = 3'd1;
                3'd2:       o = 3'd2;
                3'd3:       o = 3'd4;
                3'd4:       o = 3'd5;
                default:    o = 3'd6;
            endcase
            if (o == 3'd6) cmp_check("random", 64'(lf[9:8]));
            else begin
                do_op(o, int'(lf[7:4]), 64'(lf[9:8]), lf[11] & lf[12]);
                check_free("R4 R5 random");
            end
        end
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_wr_rd();
        t_fill();
        t_marks();
        t_compare();
        t_random();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule